// File: doc/BRIEF.md
# Tone-Pair Guard-Time Steering Validator

This block sits after a dual-tone decoder. It decides when a decoded digit counts as a real key press. The decoder raises an early-steering strobe as soon as it sees a tone pair, and it presents a 4-bit digit code alongside it. The validator accepts the digit only after the strobe has stayed high for a programmable number of clock cycles. At that point it latches the code into a receive data register and raises a guard-time output. Two cycles later it raises a delayed-steering flag. The flag is also shown as a status bit, and it can drive an active-low interrupt.

The block applies the same test when the tone goes away. The flag and the guard-time output clear only after the strobe has stayed low for a second programmable count. A dropout shorter than that count is ignored, and the digit stays registered. Because the present and absent guard counts are set independently, the accept and release points can differ, which gives hysteresis. The latched code is put on the read port only while the read strobe is high. Reading changes nothing inside the block.

Top module: `tone_guard_steer`

## Requirements
- R1: After synchronous reset, gt_o = 0, dly_flag_o = 0, status_o = 0 and irq_n_o = 1, and the latched code is 0, so rdata_o = 0 even while rd_i = 1.
- R2: When the block is idle, a digit is registered at the clock edge at which est_i has been sampled high on gtp_i+1 consecutive edges. A value of gtp_i = 0 means the first high sample registers the digit.
- R3: If est_i is sampled low before the present count completes, the count restarts from zero and nothing is registered.
- R4: On registration, the code_i sampled at that edge is latched. rdata_o shows the latched code while rd_i = 1 and shows 4'h0 while rd_i = 0.
- R5: gt_o rises at the registration edge. It stays high while est_i stays high and until the absent guard expires.
- R6: dly_flag_o rises exactly two clock edges after the registration edge, provided the absent guard has not expired in between.
- R7: status_o always equals dly_flag_o.
- R8: irq_n_o is 0 exactly when irq_en_i = 1 and dly_flag_o = 1. Otherwise it is 1.
- R9: While a digit is registered, gt_o and dly_flag_o clear at the edge at which est_i has been sampled low on gta_i+1 consecutive edges. A shorter low stretch resets the absent count and leaves both outputs set.
- R10: If the absent guard expires at or before the edge at which the settling delay would end, the release takes priority and dly_flag_o never rises for that digit.
- R11: The read strobe rd_i changes neither the latched code nor dly_flag_o.
- R12: Changes on code_i while a digit is registered do not alter the latched code. The code is updated only by a new registration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| est_i | input | 1 | Early-steering strobe from the tone decoder |
| code_i | input | 4 | Decoded digit code |
| rd_i | input | 1 | Read strobe for the receive data register |
| irq_en_i | input | 1 | Interrupt mode enable |
| gtp_i | input | 16 | Tone-present guard count, in clock cycles |
| gta_i | input | 16 | Tone-absent guard count, in clock cycles |
| gt_o | output | 1 | Guard-time output: high while a digit is registered |
| rdata_o | output | 4 | Receive data register contents, shown while rd_i is high |
| dly_flag_o | output | 1 | Delayed-steering flag |
| status_o | output | 1 | Status bit that mirrors the delayed flag |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
The end of the settling delay and the expiry of the absent guard can fall on the same clock edge. One directed case sets the present count to 0 and the absent count to 1, then holds the strobe high for a single sample. This makes the release edge coincide with the edge at which the flag would rise. The bench judges this case by requiring the flag to stay low throughout while gt_o pulses for exactly two cycles. A behavioural model, compared on every cycle during a long randomized run, also covers releases that arrive one edge earlier and all later overlaps.

// File: rtl/tgs_pkg.sv
package tgs_pkg;

    localparam int unsigned DIGIT_W    = 4;
    localparam int unsigned SETTLE_CYC = 2;
    localparam int unsigned N_GUARDS   = 2;
    localparam int unsigned G_PRESENT  = 0;
    localparam int unsigned G_ABSENT   = 1;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_HELD = 1'b1
    } steer_st_e;

    typedef struct packed {
        steer_st_e st;
        digit_t    code;
    } rx_state_t;

    function automatic digit_t bus_view(input logic rd, input digit_t code);
        return rd ? code : '0;
    endfunction

    function automatic logic irq_level_n(input logic en, input logic flag);
        return !(en && flag);
    endfunction

endpackage

// File: rtl/tgs_guard_timer.sv
module tgs_guard_timer #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          expire
);
    logic [CW-1:0] cnt_q;

    assign expire = run && (cnt_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || !run || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tgs_settle_line.sv
module tgs_settle_line #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic kill,
    output logic done
);
    logic [DEPTH-1:0] sr_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst || kill) sr_q <= '0;
                else             sr_q <= start;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst || kill) sr_q <= '0;
                else             sr_q <= {sr_q[DEPTH-2:0], start};
            end
        end
    endgenerate

    assign done = sr_q[DEPTH-1];
endmodule

// File: rtl/tone_guard_steer.sv
module tone_guard_steer
    import tgs_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          est_i,
    input  logic [3:0]    code_i,
    input  logic          rd_i,
    input  logic          irq_en_i,
    input  logic [CW-1:0] gtp_i,
    input  logic [CW-1:0] gta_i,
    output logic          gt_o,
    output logic [3:0]    rdata_o,
    output logic          dly_flag_o,
    output logic          status_o,
    output logic          irq_n_o
);
    rx_state_t     rx_q;
    logic          flag_q;
    logic          held;
    logic [N_GUARDS-1:0] g_run;
    logic [N_GUARDS-1:0] g_exp;
    logic [CW-1:0] g_lim [N_GUARDS];
    logic          accept;
    logic          release_now;
    logic          settled;

    assign held = (rx_q.st == ST_HELD);

    // Guard windows: present runs while waiting with strobe high,
    // absent runs while holding with strobe low.
    assign g_run[G_PRESENT] = !held &&  est_i;
    assign g_run[G_ABSENT]  =  held && !est_i;
    assign g_lim[G_PRESENT] = gtp_i;
    assign g_lim[G_ABSENT]  = gta_i;

    generate
        for (genvar g = 0; g < N_GUARDS; g++) begin : g_guard
            tgs_guard_timer #(.CW(CW)) i_timer (
                .clk    (clk),
                .rst    (rst),
                .run    (g_run[g]),
                .limit  (g_lim[g]),
                .expire (g_exp[g])
            );
        end
    endgenerate

    assign accept      = g_exp[G_PRESENT];
    assign release_now = g_exp[G_ABSENT];

    tgs_settle_line #(.DEPTH(SETTLE_CYC)) i_settle (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .kill  (release_now),
        .done  (settled)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q.st   <= ST_WAIT;
            rx_q.code <= '0;
        end else if (accept) begin
            rx_q.st   <= ST_HELD;
            rx_q.code <= code_i;
        end else if (release_now) begin
            rx_q.st   <= ST_WAIT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || release_now) flag_q <= 1'b0;
        else if (settled)       flag_q <= 1'b1;
    end

    assign gt_o       = held;
    assign rdata_o    = bus_view(rd_i, rx_q.code);
    assign dly_flag_o = flag_q;
    assign status_o   = flag_q;
    assign irq_n_o    = irq_level_n(irq_en_i, flag_q);
endmodule

// File: rtl/tgs_checker.sv
module tgs_checker #(
    parameter int unsigned CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          est_i,
    input logic          rd_i,
    input logic          irq_en_i,
    input logic          gt_o,
    input logic [3:0]    rdata_o,
    input logic          dly_flag_o,
    input logic          status_o,
    input logic          irq_n_o
);
    a_r7_status_is_flag: assert property (@(posedge clk) disable iff (rst)
        status_o == dly_flag_o);

    a_r8_irq_level: assert property (@(posedge clk) disable iff (rst)
        irq_n_o == !(irq_en_i && dly_flag_o));

    a_r2_rise_needs_est: assert property (@(posedge clk) disable iff (rst)
        $rose(gt_o) |-> $past(est_i));

    a_r5_gt_holds_on_est: assert property (@(posedge clk) disable iff (rst)
        (gt_o && est_i) |=> gt_o);

    a_r6_flag_after_gt: assert property (@(posedge clk) disable iff (rst)
        $rose(dly_flag_o) |-> ($past(gt_o, 1) && $past(gt_o, 2) && gt_o));

    a_r9_release_on_low: assert property (@(posedge clk) disable iff (rst)
        $fell(gt_o) |-> !$past(est_i));

    a_r9_flag_needs_gt: assert property (@(posedge clk) disable iff (rst)
        dly_flag_o |-> gt_o);

    a_r12_code_stable: assert property (@(posedge clk) disable iff (rst)
        (rd_i && $past(rd_i) && !$rose(gt_o)) |-> $stable(rdata_o));
endmodule

bind tone_guard_steer tgs_checker #(.CW(CW)) i_tgs_checker (
    .clk        (clk),
    .rst        (rst),
    .est_i      (est_i),
    .rd_i       (rd_i),
    .irq_en_i   (irq_en_i),
    .gt_o       (gt_o),
    .rdata_o    (rdata_o),
    .dly_flag_o (dly_flag_o),
    .status_o   (status_o),
    .irq_n_o    (irq_n_o)
);

// File: tb/test_tone_guard_steer.sv
module test_tone_guard_steer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        est = 1'b0;
    logic [3:0]  code = 4'h0;
    logic        rd = 1'b1;
    logic        irq_en = 1'b1;
    logic [15:0] gtp = 16'd3;
    logic [15:0] gta = 16'd2;
    logic        gt, flag, status, irq_n;
    logic [3:0]  rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit cmp_on = 1'b0;

    // behavioural reference state
    int m_held = 0, m_cnt = 0, m_code = 0, m_pend = 0, m_flag = 0;

    always #4 clk = ~clk;

    tone_guard_steer i_tone_guard_steer (
        .clk(clk), .rst(rst), .est_i(est), .code_i(code), .rd_i(rd),
        .irq_en_i(irq_en), .gtp_i(gtp), .gta_i(gta), .gt_o(gt),
        .rdata_o(rdata), .dly_flag_o(flag), .status_o(status), .irq_n_o(irq_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_held = 0; m_cnt = 0; m_code = 0; m_pend = 0; m_flag = 0;
        end else if (m_held == 0) begin
            if (est) begin
                if (m_cnt >= int'(gtp)) begin
                    m_held = 1; m_code = int'(code); m_cnt = 0; m_pend = 2;
                end else m_cnt++;
            end else m_cnt = 0;
        end else begin
            if (!est && m_cnt >= int'(gta)) begin
                m_held = 0; m_flag = 0; m_pend = 0; m_cnt = 0;
            end else begin
                if (est) m_cnt = 0; else m_cnt++;
                if (m_pend > 0) begin
                    m_pend--;
                    if (m_pend == 0) m_flag = 1;
                end
            end
        end
        cmp_on = 1'b1;
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R5 model gt", int'(gt), m_held);
            chk("R6 model flag", int'(flag), m_flag);
            chk("R7 model status", int'(status), m_flag);
            chk("R8 model irq_n", int'(irq_n), (irq_en && m_flag != 0) ? 0 : 1);
            chk("R4 model rdata", int'(rdata), rd ? m_code : 0);
        end
    end

    task automatic drive(input logic e, input logic [3:0] c, input logic r);
        @(posedge clk); #2;
        est = e; code = c; rd = r;
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset gt", int'(gt), 0);
        chk("R1 reset flag", int'(flag), 0);
        chk("R1 reset irq_n", int'(irq_n), 1);
        chk("R1 reset rdata", int'(rdata), 0);
        @(posedge clk); #2; rst = 1'b0;

        // R2/R4/R6: present guard 3 -> register on fourth high sample
        drive(1'b1, 4'h5, 1'b1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R2 not yet registered", int'(gt), 0);
        end
        @(negedge clk);
        chk("R2 registered", int'(gt), 1);
        chk("R4 code latched", int'(rdata), 5);
        chk("R6 flag settling", int'(flag), 0);
        @(negedge clk);
        chk("R6 flag settling", int'(flag), 0);
        @(negedge clk);
        chk("R6 flag up", int'(flag), 1);
        chk("R7 status", int'(status), 1);
        chk("R8 irq low", int'(irq_n), 0);

        // R12: code changes while held are ignored
        drive(1'b1, 4'h9, 1'b1);
        @(negedge clk);
        chk("R12 code kept", int'(rdata), 5);
        // R11: reads do not disturb the latch or flag
        drive(1'b1, 4'h9, 1'b0);
        @(negedge clk);
        chk("R4 bus idle", int'(rdata), 0);
        drive(1'b1, 4'h9, 1'b1);
        @(negedge clk);
        chk("R11 code after read", int'(rdata), 5);
        chk("R11 flag after read", int'(flag), 1);
        irq_en = 1'b0;
        @(negedge clk);
        chk("R8 irq masked", int'(irq_n), 1);
        irq_en = 1'b1;

        // R9: dropout of two samples with gta=2 is tolerated
        drive(1'b0, 4'h9, 1'b1);
        drive(1'b0, 4'h9, 1'b1);
        drive(1'b1, 4'h9, 1'b1);
        @(negedge clk);
        chk("R9 dropout tolerated gt", int'(gt), 1);
        chk("R9 dropout tolerated flag", int'(flag), 1);
        // R9: three low samples release
        drive(1'b0, 4'h9, 1'b1);
        @(negedge clk);
        chk("R9 still held", int'(flag), 1);
        @(negedge clk);
        chk("R9 still held", int'(flag), 1);
        @(negedge clk);
        chk("R9 still held", int'(flag), 1);
        @(negedge clk);
        chk("R9 released flag", int'(flag), 0);
        chk("R9 released gt", int'(gt), 0);
        repeat (6) drive(1'b0, 4'h0, 1'b1);

        // R3: interrupted present timing restarts
        drive(1'b1, 4'h3, 1'b1);
        drive(1'b1, 4'h3, 1'b1);
        drive(1'b0, 4'h3, 1'b1);
        drive(1'b1, 4'h7, 1'b1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R3 restart no register", int'(gt), 0);
        end
        @(negedge clk);
        chk("R3 register after restart", int'(gt), 1);
        chk("R3 code", int'(rdata), 7);
        repeat (8) drive(1'b0, 4'h0, 1'b1);

        // R10: release coincides with settle end; R2 zero count
        gtp = 16'd0; gta = 16'd1;
        drive(1'b1, 4'hc, 1'b1);
        drive(1'b0, 4'hc, 1'b1);
        @(negedge clk);
        chk("R2 zero count registers", int'(gt), 1);
        chk("R10 flag low", int'(flag), 0);
        @(negedge clk);
        chk("R10 gt held", int'(gt), 1);
        chk("R10 flag low", int'(flag), 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R10 gt released", int'(gt), 0);
            chk("R10 flag never rose", int'(flag), 0);
        end

        // randomized run against the model
        for (int seg = 0; seg < 12; seg++) begin
            repeat (20) drive(1'b0, 4'h0, 1'b1);
            gtp = 16'($urandom_range(0, 6));
            gta = 16'($urandom_range(0, 6));
            for (int k = 0; k < 300; k++) begin
                logic e;
                e = ($urandom_range(0, 9) < 6) ? est : ~est;
                irq_en = 1'($urandom_range(0, 1));
                drive(e, 4'($urandom_range(0, 15)), ($urandom_range(0, 3) != 0));
            end
        end

        @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule